// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. Four wires drive it: a test clock, a mode-select line, a serial data input and a reset that is sampled on the test clock. It runs the standard sixteen-state port sequencer and holds a 4-bit instruction. It decodes that instruction to choose which data register sits between the serial input and the serial output: a one-bit pass-through stage, a 32-bit identification register, or an external boundary-scan chain that is reached through a select line and a return-data input.

Besides the serial path, the block gives the boundary cells their control signals. It drives capture, shift and update strobes for the data side. It also drives two mode levels. One tells the cells to take over the device pins instead of passing system values through. The other tells them to turn the pin drivers off. A test controller loads an instruction, optionally preloads the chain, and then scans data. The serial output changes on the falling test-clock edge and is enabled only while a shift state is active.

Top module: `tap_ctrl`

## Requirements
- R1: The sequencer follows the standard sixteen-state graph. `capture_dr`, `shift_dr` and `update_dr` are high exactly while the sequencer is in Capture-DR, Shift-DR and Update-DR.
- R2: Five consecutive rising edges with `tms` high bring the sequencer to Test-Logic-Reset from any state. `trst` high on a rising edge does the same at once. In Test-Logic-Reset the instruction becomes IDCODE (1110).
- R3: Capture-IR loads 4'b0001 into the instruction shift stage, which shifts out least significant bit first. Update-IR copies the shift stage into the active instruction.
- R4: Opcodes are EXTEST 0000, SAMPLE 0011, CLAMP 0101, HIGHZ 0111, CLAMPZ 1001, INTEST 1100, IDCODE 1110 and BYPASS 1111. CLAMP, HIGHZ, CLAMPZ, BYPASS and every unlisted code route the one-bit pass-through stage to `tdo`.
- R5: The pass-through stage loads 0 in Capture-DR and takes `tdi` on each Shift-DR edge, so `tdo` gives a 0 and then `tdi` delayed by one TCK. Update-DR leaves it unchanged.
- R6: Under IDCODE, Capture-DR loads the constant `ID_VALUE` into the 32-bit register, Shift-DR moves it out least significant bit first while `tdi` enters at the top, and Update-DR has no effect. A later capture again returns `ID_VALUE`.
- R7: EXTEST, SAMPLE and INTEST raise `bsr_select` and route `bsr_tdo` to `tdo` during Shift-DR. All other codes keep `bsr_select` low.
- R8: `test_mode` is high for EXTEST, INTEST, CLAMP, HIGHZ and CLAMPZ. It is low for BYPASS, IDCODE, SAMPLE and unlisted codes, and low after reset.
- R9: `out_hiz` is high only for HIGHZ and CLAMPZ.
- R10: `tdo` and `tdo_oe` update on the falling edge of `tck`. `tdo_oe` is high only during Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Active-high port reset, sampled on rising `tck` |
| tms | input | 1 | Mode select steering the sequencer |
| tdi | input | 1 | Serial data in |
| bsr_tdo | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| capture_dr | output | 1 | High in Capture-DR |
| shift_dr | output | 1 | High in Shift-DR |
| update_dr | output | 1 | High in Update-DR |
| bsr_select | output | 1 | Boundary chain is the active data register |
| test_mode | output | 1 | Boundary cells drive the pins from their latches |
| out_hiz | output | 1 | Boundary cells disable output drivers |

## Verification
Several rules are checked by assertions on every rising edge: the five-edge `tms` return to reset, the instruction transfer in Update-IR, the zero capture and one-edge shift of the pass-through stage, the identification capture, the output-enable timing and the relations between the mode levels. Other behaviours can only be seen in the bench's directed scans. These are the serial bit order seen at `tdo`, the 0001 capture pattern, the per-opcode routing including unlisted codes, the return path from the boundary chain, and the recovery from either reset method.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_PASS, DR_IDENT, DR_CHAIN} dr_sel_t;

  typedef struct packed {
    dr_sel_t sel;
    logic    test_mode;
    logic    hiz;
  } ir_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0011;
  localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0101;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0111;
  localparam logic [IR_W-1:0] OP_CLAMPZ = 4'b1001;
  localparam logic [IR_W-1:0] OP_INTEST = 4'b1100;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b1110;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_TLR;
    else      state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q,
  output ir_dec_t         dec
);
  always_ff @(posedge tck) begin
    if (trst || state == ST_TLR) begin
      ir_sh <= IR_CAPTURE_PAT;
      ir_q  <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE_PAT;
      if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (state == ST_UPD_IR) ir_q  <= ir_sh;
    end
  end

  always_comb begin
    dec = '{sel: DR_PASS, test_mode: 1'b0, hiz: 1'b0};
    unique case (ir_q)
      OP_IDCODE: dec.sel = DR_IDENT;
      OP_SAMPLE: dec.sel = DR_CHAIN;
      OP_EXTEST,
      OP_INTEST: begin dec.sel = DR_CHAIN; dec.test_mode = 1'b1; end
      OP_CLAMP:  dec.test_mode = 1'b1;
      OP_HIGHZ,
      OP_CLAMPZ: begin dec.test_mode = 1'b1; dec.hiz = 1'b1; end
      default:   dec.sel = DR_PASS;
    endcase
  end
endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1F0C_5A35
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_state_t      state,
  input  dr_sel_t         sel,
  input  logic            ir_out,
  input  logic            bsr_tdo,
  output logic            bypass_q,
  output logic [ID_W-1:0] id_sh,
  output logic            tdo,
  output logic            tdo_oe
);
  logic sh_ir, sh_dr, dr_bit, nxt_bit;

  assign sh_ir = (state == ST_SH_IR);
  assign sh_dr = (state == ST_SH_DR);

  always_ff @(posedge tck) begin
    if (trst) begin
      bypass_q <= 1'b0;
      id_sh    <= ID_VALUE;
    end else begin
      if (sel == DR_PASS) begin
        if (state == ST_CAP_DR) bypass_q <= 1'b0;
        else if (sh_dr)         bypass_q <= tdi;
      end
      if (sel == DR_IDENT) begin
        if (state == ST_CAP_DR) id_sh <= ID_VALUE;
        else if (sh_dr)         id_sh <= {tdi, id_sh[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    unique case (sel)
      DR_IDENT: dr_bit = id_sh[0];
      DR_CHAIN: dr_bit = bsr_tdo;
      default:  dr_bit = bypass_q;
    endcase
    nxt_bit = sh_ir ? ir_out : (sh_dr ? dr_bit : 1'b0);
  end

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= nxt_bit;
      tdo_oe <= sh_ir | sh_dr;
    end
  end
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1F0C_5A35
) (
  input  logic tck,
  input  logic trst,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic capture_dr,
  output logic shift_dr,
  output logic update_dr,
  output logic bsr_select,
  output logic test_mode,
  output logic out_hiz
);
  tap_state_t      state;
  logic [IR_W-1:0] ir_sh, ir_q;
  ir_dec_t         dec;
  logic            bypass_q;
  logic [ID_W-1:0] id_sh;

  tap_fsm fsm_i (.tck(tck), .trst(trst), .tms(tms), .state(state));

  tap_ir ir_i (
    .tck(tck), .trst(trst), .tdi(tdi), .state(state),
    .ir_sh(ir_sh), .ir_q(ir_q), .dec(dec)
  );

  tap_dr_path #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) dr_i (
    .tck(tck), .trst(trst), .tdi(tdi), .state(state), .sel(dec.sel),
    .ir_out(ir_sh[0]), .bsr_tdo(bsr_tdo), .bypass_q(bypass_q), .id_sh(id_sh),
    .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign capture_dr = (state == ST_CAP_DR);
  assign shift_dr   = (state == ST_SH_DR);
  assign update_dr  = (state == ST_UPD_DR);
  assign bsr_select = (dec.sel == DR_CHAIN);
  assign test_mode  = dec.test_mode;
  assign out_hiz    = dec.hiz;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1F0C_5A35
) (
  input logic            tck,
  input logic            trst,
  input logic            tms,
  input logic            tdi,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_sh,
  input logic [IR_W-1:0] ir_q,
  input logic            bypass_sel,
  input logic            bypass_q,
  input logic [ID_W-1:0] id_sh,
  input logic            tdo_oe,
  input logic            test_mode,
  input logic            out_hiz
);
  assert_tms_reset_R2: assert property (@(posedge tck) disable iff (trst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_TLR);

  assert_ir_update_R3: assert property (@(posedge tck) disable iff (trst)
    (state == ST_UPD_IR) |=> ir_q == $past(ir_sh));

  assert_pass_capture_R5: assert property (@(posedge tck) disable iff (trst)
    (state == ST_CAP_DR && bypass_sel) |=> !bypass_q);

  assert_pass_shift_R5: assert property (@(posedge tck) disable iff (trst)
    (state == ST_SH_DR && bypass_sel) |=> bypass_q == $past(tdi));

  assert_id_capture_R6: assert property (@(posedge tck) disable iff (trst)
    (state == ST_CAP_DR && ir_q == OP_IDCODE) |=> id_sh == ID_VALUE);

  assert_normal_mode_R8: assert property (@(posedge tck) disable iff (trst)
    (ir_q == OP_IDCODE || ir_q == OP_BYPASS) |-> !test_mode);

  assert_hiz_in_test_R9: assert property (@(posedge tck) disable iff (trst)
    out_hiz |-> test_mode);

  assert_oe_window_R10: assert property (@(posedge tck) disable iff (trst)
    tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));
endmodule

bind tap_ctrl tap_ctrl_chk #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) chk_i (
  .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .state(state), .ir_sh(ir_sh),
  .ir_q(ir_q), .bypass_sel(dec.sel == tap_pkg::DR_PASS), .bypass_q(bypass_q),
  .id_sh(id_sh), .tdo_oe(tdo_oe), .test_mode(test_mode), .out_hiz(out_hiz)
);

// File: tb/tap_ctrl_tb_top.sv
module tap_ctrl_tb_top;
  localparam int          TCK_PERIOD = 20;
  localparam logic [31:0] IDV = 32'h1F0C_5A35;

  logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
  logic tdo, tdo_oe, capture_dr, shift_dr, update_dr, bsr_select, test_mode, out_hiz;
  logic s_cap, s_sh, s_upd, s_oe;
  int n_vec = 0, n_bad = 0;

  always #(TCK_PERIOD / 2) tck = ~tck;

  tap_ctrl #(.ID_W(32), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo), .tdo(tdo),
    .tdo_oe(tdo_oe), .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .bsr_select(bsr_select), .test_mode(test_mode), .out_hiz(out_hiz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // samples outputs just after the falling edge, then drives inputs for the next rising edge
  task automatic step(input logic m, input logic d, input logic b, output logic o);
    @(negedge tck); #1;
    o = tdo; s_cap = capture_dr; s_sh = shift_dr; s_upd = update_dr; s_oe = tdo_oe;
    tms = m; tdi = d; bsr_tdo = b;
  endtask

  task automatic to_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, o);
    step(1'b0, 1'b0, 1'b0, o);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o;
    step(1'b1, 1'b0, 1'b0, o); step(1'b1, 1'b0, 1'b0, o);
    step(1'b0, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], 1'b0, o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    step(1'b0, 1'b0, 1'b0, o);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, input logic [31:0] bpat,
                         output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    step(1'b0, 1'b0, bpat[0], o);
    chk("R1 capture_dr strobe", {31'd0, s_cap}, 32'd1);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], bpat[(i + 1) % 32], o);
      dout[i] = o;
      if (i == 0) begin
        chk("R1 shift_dr strobe", {31'd0, s_sh}, 32'd1);
        chk("R10 tdo_oe in shift", {31'd0, s_oe}, 32'd1);
      end
    end
    step(1'b1, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    chk("R1 update_dr strobe", {31'd0, s_upd}, 32'd1);
    step(1'b0, 1'b0, 1'b0, o);
    chk("R10 tdo low when disabled", {30'd0, s_oe, o}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(posedge tck);
    @(negedge tck); trst = 1'b0; tms = 1'b0;
    #1;
    chk("R8 test_mode after reset", {31'd0, test_mode}, 32'd0);
    chk("R7 bsr_select after reset", {31'd0, bsr_select}, 32'd0);
    to_idle();
    scan_dr(32, 32'hFFFF_FFFF, 32'd0, d);
    chk("R2 reset instruction is IDCODE", d, IDV);
    scan_dr(32, 32'h0, 32'd0, d);
    chk("R6 recapture after update", d, IDV);
  endtask

  task automatic t_bypass(input logic [3:0] op, input string req);
    logic [3:0] c;
    logic [31:0] d;
    load_ir(op, c);
    chk("R3 capture pattern 0001", {28'd0, c}, 32'd1);
    chk({req, " bsr_select low"}, {31'd0, bsr_select}, 32'd0);
    scan_dr(8, 32'h0000_00B6, 32'hFFFF_FFFF, d);
    chk({req, " one-bit path"}, d[7:0], 32'h0000_006C);
  endtask

  task automatic t_modes(input logic [3:0] op, input logic tm, input logic hz,
                         input logic bs);
    logic [3:0] c;
    load_ir(op, c);
    chk("R8 test_mode decode", {31'd0, test_mode}, {31'd0, tm});
    chk("R9 out_hiz decode", {31'd0, out_hiz}, {31'd0, hz});
    chk("R7 bsr_select decode", {31'd0, bsr_select}, {31'd0, bs});
  endtask

  task automatic t_chain();
    logic [3:0] c;
    logic [31:0] d;
    load_ir(4'b1100, c);
    scan_dr(12, 32'h0, 32'h0000_0A5C, d);
    chk("R7 tdo follows bsr_tdo", d[11:0], 32'h0000_0A5C);
  endtask

  task automatic t_tms_reset();
    logic [3:0] c;
    logic [31:0] d;
    logic o;
    load_ir(4'b0101, c);
    step(1'b1, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, o);
    step(1'b0, 1'b0, 1'b0, o); step(1'b0, 1'b0, 1'b0, o);
    chk("R2 tms reset clears test_mode", {31'd0, test_mode}, 32'd0);
    scan_dr(32, 32'h1234_5678, 32'd0, d);
    chk("R2 tms reset restores IDCODE", d, IDV);
  endtask

  task automatic t_trst();
    logic [3:0] c;
    logic [31:0] d;
    load_ir(4'b0111, c);
    chk("R9 HIGHZ before trst", {31'd0, out_hiz}, 32'd1);
    @(negedge tck); trst = 1'b1;
    @(negedge tck); trst = 1'b0; tms = 1'b0;
    #1;
    chk("R2 trst clears out_hiz", {31'd0, out_hiz}, 32'd0);
    @(negedge tck);
    scan_dr(32, 32'h0, 32'd0, d);
    chk("R2 trst restores IDCODE", d, IDV);
  endtask

  initial begin
    s_cap = 0; s_sh = 0; s_upd = 0; s_oe = 0;
    t_reset();
    t_bypass(4'b1111, "R4 BYPASS R5");
    t_bypass(4'b0101, "R4 CLAMP");
    t_bypass(4'b0111, "R4 HIGHZ");
    t_bypass(4'b1001, "R4 CLAMPZ");
    t_bypass(4'b1010, "R4 undefined code");
    t_modes(4'b0000, 1'b1, 1'b0, 1'b1);
    t_modes(4'b0011, 1'b0, 1'b0, 1'b1);
    t_modes(4'b0101, 1'b1, 1'b0, 1'b0);
    t_modes(4'b0111, 1'b1, 1'b1, 1'b0);
    t_modes(4'b1001, 1'b1, 1'b1, 1'b0);
    t_modes(4'b1100, 1'b1, 1'b0, 1'b1);
    t_modes(4'b1110, 1'b0, 1'b0, 1'b0);
    t_modes(4'b1111, 1'b0, 1'b0, 1'b0);
    t_modes(4'b0110, 1'b0, 1'b0, 1'b0);
    t_chain();
    t_tms_reset();
    t_trst();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule